// File: doc/BRIEF.md
# SDRAM Open-Page Hit Tracker

This block records, for every internal sub-bank ("leaf") of an SDRAM array, which row is currently open. The array is split into two banks with four leaves each, giving eight leaves. Each leaf has one page register and one valid bit. A memory controller presents each access address to the tracker. One clock later the tracker answers with the decoded bank and leaf, the row that the access needs, and whether that row is already open (hit), another row is open in that leaf (miss), or the leaf holds no open row (closed). The controller uses this answer to choose between a direct read or write, a precharge followed by an activate, or a plain activate.

The controller also reports its own commands back. An activate-done pulse records a newly opened row in its leaf, and this replaces whatever row that leaf held before. A precharge-done pulse closes one leaf. A close-all pulse, issued for example before refresh, closes all eight leaves. A two-bit size setting selects a 64, 128 or 256 Mbyte array. The setting moves the bank and leaf select bits, because the bank bit is always the top bit of the configured memory space. The lowest 11 address bits are always the byte offset inside a 2 Kbyte page.

Top module: `sdram_page_tracker`

## Requirements
- R1: After reset `rsp_valid` is 0 and all eight leaves are closed, so any request made before an activate is classified closed.
- R2: A request with `req_valid`=1 produces `rsp_valid`=1 exactly one clock later, carrying that request's results. A cycle with no request produces `rsp_valid`=0 one clock later.
- R3: With `mem_size`=0 (64 Mbyte) the bank is address bit 25, the leaf is bits [24:23] and the row is bits [22:11], zero-extended. Address bits above 25 are ignored.
- R4: With `mem_size`=1 (128 Mbyte) the bank is bit 26, the leaf is bits [25:24] and the row is bits [23:11]. Bit 27 is ignored.
- R5: With `mem_size`=2 or 3 (256 Mbyte) the bank is bit 27, the leaf is bits [26:25] and the row is bits [24:11].
- R6: `rsp_class` uses 0 for closed, 1 for hit and 2 for miss, and never takes the value 3. Hit means the leaf is valid and its stored row equals the request row. Miss means the leaf is valid and holds a different row. Closed means the leaf is not valid.
- R7: `act_done` stores the row of `cmd_addr` in the leaf of `cmd_addr` and marks that leaf open. Any row the leaf held before is replaced, and the other leaves are unchanged.
- R8: `pre_done` closes the leaf of `cmd_addr`. When `act_done` and `pre_done` are both high in the same cycle, the activate takes effect and the leaf ends open.
- R9: `close_all` closes all eight leaves. It takes priority over `act_done` and `pre_done` in the same cycle.
- R10: A cycle in which `mem_size` differs from its value in the previous clock closes all leaves, and takes priority over any activate in that cycle.
- R11: A request is classified against the leaf state held before the clock edge at which it is sampled. An update in the same cycle affects only later requests.
- R12: Address bits [10:0] have no effect on any response field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_size | input | 2 | Array size: 0=64 MB, 1=128 MB, 2 or 3=256 MB |
| req_valid | input | 1 | An access address is presented this cycle |
| req_addr | input | ADDR_W (28) | Byte address of the access |
| act_done | input | 1 | Activate completed at `cmd_addr` |
| pre_done | input | 1 | Precharge completed at `cmd_addr` |
| cmd_addr | input | ADDR_W (28) | Address of the completed command |
| close_all | input | 1 | Close every leaf |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_bank | output | 1 | Decoded bank |
| rsp_leaf | output | 2 | Decoded leaf within the bank |
| rsp_class | output | 2 | 0 closed, 1 hit, 2 miss |
| rsp_row | output | PAGE_W (14) | Row of the request, i.e. the row to activate |

## Verification
Random traffic reuses a small pool of rows in every leaf, so that hits, misses and closed leaves all occur often and a wrong row compare shows up as a hit or miss in the wrong place. The random stream also mixes activates, precharges, close-all pulses and rare size changes. Noise in the offset bits and in the bits above the memory space separates correct field slicing from slicing that is off by one position. Directed sequences cover the collisions in which two actions arrive at one edge: an activate together with a precharge, a close-all together with an activate, a request sampled at the same edge as the activate of its own row, and a size change right after a row has been opened.

// File: rtl/pgtrk_pkg.sv
// Shared constants and types of the SDRAM open-page tracker.
// Assumes: two banks of four leaves; the page offset width is fixed.
package pgtrk_pkg;
    localparam int NUM_BANKS       = 2;
    localparam int LEAVES_PER_BANK = 4;
    localparam int NUM_LEAVES      = NUM_BANKS * LEAVES_PER_BANK;
    localparam int IDX_W           = $clog2(NUM_LEAVES);
    localparam int OFS_W           = 11;

    typedef enum logic [1:0] {
        PG_CLOSED = 2'd0,
        PG_HIT    = 2'd1,
        PG_MISS   = 2'd2
    } pg_class_e;
endpackage

// File: rtl/pgtrk_addr_split.sv
// Splits a byte address into bank, leaf and row according to the size code.
// Assumes: ADDR_W covers the largest (256 MB) array; smaller arrays use
// one or two fewer top bits. The row is zero-extended to PAGE_W bits.
module pgtrk_addr_split
    import pgtrk_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int PAGE_W = ADDR_W - IDX_W - OFS_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              bank,
    output logic [1:0]        leaf,
    output logic [PAGE_W-1:0] row
);
    localparam int TOP_S = ADDR_W - 3;   // bank bit, smallest array
    localparam int TOP_M = ADDR_W - 2;   // bank bit, middle array
    localparam int TOP_L = ADDR_W - 1;   // bank bit, largest array

    // Select the bank, leaf and row fields for the configured array size.
    always_comb begin
        case (size)
            2'd0: begin
                bank = addr[TOP_S];
                leaf = addr[TOP_S-1:TOP_S-2];
                row  = PAGE_W'(addr[TOP_S-3:OFS_W]);
            end
            2'd1: begin
                bank = addr[TOP_M];
                leaf = addr[TOP_M-1:TOP_M-2];
                row  = PAGE_W'(addr[TOP_M-3:OFS_W]);
            end
            default: begin
                bank = addr[TOP_L];
                leaf = addr[TOP_L-1:TOP_L-2];
                row  = PAGE_W'(addr[TOP_L-3:OFS_W]);
            end
        endcase
    end
endmodule

// File: rtl/pgtrk_leaf_regs.sv
// One page register and one valid bit per leaf, with a combinational read port.
// Assumes: clear-all outranks set, and set outranks single-leaf clear.
module pgtrk_leaf_regs
    import pgtrk_pkg::*;
#(
    parameter int PAGE_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic [PAGE_W-1:0] set_page,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [PAGE_W-1:0] rd_page
);
    logic [NUM_LEAVES-1:0] open_q;
    logic [PAGE_W-1:0]     page_q [NUM_LEAVES];

    for (genvar g = 0; g < NUM_LEAVES; g++) begin : g_leaf
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);

        // Valid bit of this leaf, updated by priority: clear-all, set, clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                           open_q[g] <= 1'b0;
            else if (clr_all)                     open_q[g] <= 1'b0;
            else if (set_en && set_idx == MY_IDX) open_q[g] <= 1'b1;
            else if (clr_en && clr_idx == MY_IDX) open_q[g] <= 1'b0;
        end

        // Row number held by this leaf, written on an accepted activate.
        always_ff @(posedge clk) begin
            if (!rst_n)
                page_q[g] <= '0;
            else if (!clr_all && set_en && set_idx == MY_IDX)
                page_q[g] <= set_page;
        end
    end

    // Read port for the leaf addressed by the current request.
    always_comb begin
        rd_valid = open_q[rd_idx];
        rd_page  = page_q[rd_idx];
    end
endmodule

// File: rtl/pgtrk_classify.sv
// Compares a request row against a leaf's stored state and returns the class.
// Assumes: both rows have the same zero-extended width.
module pgtrk_classify
    import pgtrk_pkg::*;
#(
    parameter int PAGE_W = 14
) (
    input  logic              leaf_open,
    input  logic [PAGE_W-1:0] leaf_page,
    input  logic [PAGE_W-1:0] req_page,
    output pg_class_e         cls
);
    // Closed when the leaf is not open, otherwise hit or miss by row compare.
    always_comb begin
        if (!leaf_open)                 cls = PG_CLOSED;
        else if (leaf_page == req_page) cls = PG_HIT;
        else                            cls = PG_MISS;
    end
endmodule

// File: rtl/sdram_page_tracker.sv
// Top of the open-page tracker: decodes request and command addresses,
// keeps the per-leaf page registers and registers a classification one
// clock after each request.
// Assumes: command pulses refer to cmd_addr, which is decoded with the same
// size setting as the request; a change of mem_size closes every leaf.
module sdram_page_tracker
    import pgtrk_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int PAGE_W = ADDR_W - IDX_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mem_size,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              act_done,
    input  logic              pre_done,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              close_all,
    output logic              rsp_valid,
    output logic              rsp_bank,
    output logic [1:0]        rsp_leaf,
    output logic [1:0]        rsp_class,
    output logic [PAGE_W-1:0] rsp_row
);
    logic [1:0]        size_q;
    logic              size_chg;
    logic              rq_bank, cm_bank;
    logic [1:0]        rq_leaf, cm_leaf;
    logic [PAGE_W-1:0] rq_row, cm_row;
    logic              rd_valid;
    logic [PAGE_W-1:0] rd_page;
    pg_class_e         cls;

    // Remember the size setting of the previous clock to detect a change.
    always_ff @(posedge clk) begin
        if (!rst_n) size_q <= mem_size;
        else        size_q <= mem_size;
    end

    // A change of size invalidates every stored row.
    always_comb size_chg = (mem_size != size_q);

    pgtrk_addr_split #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_req_split (
        .addr(req_addr), .size(mem_size),
        .bank(rq_bank), .leaf(rq_leaf), .row(rq_row)
    );

    pgtrk_addr_split #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_cmd_split (
        .addr(cmd_addr), .size(mem_size),
        .bank(cm_bank), .leaf(cm_leaf), .row(cm_row)
    );

    pgtrk_leaf_regs #(.PAGE_W(PAGE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (close_all | size_chg),
        .clr_en   (pre_done),
        .clr_idx  ({cm_bank, cm_leaf}),
        .set_en   (act_done),
        .set_idx  ({cm_bank, cm_leaf}),
        .set_page (cm_row),
        .rd_idx   ({rq_bank, rq_leaf}),
        .rd_valid (rd_valid),
        .rd_page  (rd_page)
    );

    pgtrk_classify #(.PAGE_W(PAGE_W)) u_cls (
        .leaf_open(rd_valid), .leaf_page(rd_page), .req_page(rq_row), .cls(cls)
    );

    // Register the response fields for the request of this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_bank  <= 1'b0;
            rsp_leaf  <= '0;
            rsp_class <= PG_CLOSED;
            rsp_row   <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_bank  <= rq_bank;
                rsp_leaf  <= rq_leaf;
                rsp_class <= cls;
                rsp_row   <= rq_row;
            end
        end
    end
endmodule

// File: rtl/pgtrk_chk.sv
// Assertion checker for sdram_page_tracker, attached by bind.
// Assumes: sampled on the rising clock edge with synchronous active-low reset.
module pgtrk_chk
    import pgtrk_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int PAGE_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mem_size,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              act_done,
    input logic              pre_done,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              close_all,
    input logic              rsp_valid,
    input logic [1:0]        rsp_class
);
    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R6
    legal_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_class != 2'd3);

    // R7
    hit_after_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(act_done) && !$past(close_all)
         && req_addr == $past(cmd_addr) && mem_size == $past(mem_size)
         && $past(mem_size) == $past(mem_size, 2))
        |=> rsp_class == PG_HIT);

    // R8
    closed_after_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(pre_done) && !$past(act_done)
         && req_addr == $past(cmd_addr) && mem_size == $past(mem_size))
        |=> rsp_class == PG_CLOSED);

    // R9
    closed_after_close_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(close_all)) |=> rsp_class == PG_CLOSED);

    // R10
    closed_after_resize_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(mem_size) != $past(mem_size, 2)) |=> rsp_class == PG_CLOSED);
endmodule

bind sdram_page_tracker pgtrk_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_size(mem_size), .req_valid(req_valid),
    .req_addr(req_addr), .act_done(act_done), .pre_done(pre_done),
    .cmd_addr(cmd_addr), .close_all(close_all), .rsp_valid(rsp_valid),
    .rsp_class(rsp_class)
);

// File: tb/sdram_page_tracker_tb.sv
// Self-checking bench: reference model of the leaf table, directed corner
// cases, then seeded random traffic.
module sdram_page_tracker_tb;
    localparam int ADDR_W = 28;
    localparam int PAGE_W = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mem_size = 2'd0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              act_done = 1'b0;
    logic              pre_done = 1'b0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic              close_all = 1'b0;
    logic              rsp_valid;
    logic              rsp_bank;
    logic [1:0]        rsp_leaf;
    logic [1:0]        rsp_class;
    logic [PAGE_W-1:0] rsp_row;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    bit                m_open [8];
    logic [PAGE_W-1:0] m_page [8];
    logic [1:0]        m_size;

    always #2 clk = ~clk;

    sdram_page_tracker #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mem_size(mem_size), .req_valid(req_valid),
        .req_addr(req_addr), .act_done(act_done), .pre_done(pre_done),
        .cmd_addr(cmd_addr), .close_all(close_all), .rsp_valid(rsp_valid),
        .rsp_bank(rsp_bank), .rsp_leaf(rsp_leaf), .rsp_class(rsp_class),
        .rsp_row(rsp_row)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Bank bit position per size code (R3, R4, R5).
    function automatic int top_bit(input logic [1:0] sz);
        return (sz == 2'd0) ? 25 : (sz == 2'd1) ? 26 : 27;
    endfunction

    function automatic int dec_idx(input logic [ADDR_W-1:0] a, input logic [1:0] sz);
        int t = top_bit(sz);
        return int'((a >> (t - 2)) & 28'h7);
    endfunction

    function automatic logic [PAGE_W-1:0] dec_row(input logic [ADDR_W-1:0] a, input logic [1:0] sz);
        int t = top_bit(sz);
        logic [ADDR_W-1:0] m = (28'd1 << (t - 2)) - 28'd1;
        return PAGE_W'((a & m) >> 11);
    endfunction

    function automatic logic [ADDR_W-1:0] mk_addr(input logic [1:0] sz, input int idx,
                                                  input int row, input int ofs, input int junk);
        int t = top_bit(sz);
        logic [ADDR_W-1:0] a;
        a = (ADDR_W'(junk) << (t + 1)) | (ADDR_W'(idx) << (t - 2))
          | (ADDR_W'(row) << 11) | ADDR_W'(ofs & 11'h7ff);
        return a;
    endfunction

    function automatic int exp_class(input int idx, input logic [PAGE_W-1:0] row);
        if (!m_open[idx]) return 0;
        return (m_page[idx] == row) ? 1 : 2;
    endfunction

    // One clock: drive, predict from the pre-edge model, update model, check.
    task automatic cyc(input bit rq, input logic [ADDR_W-1:0] ra, input bit ac, input bit pr,
                       input bit ca, input logic [ADDR_W-1:0] cm, input logic [1:0] sz,
                       input string tag);
        int ecls, eidx;
        logic [PAGE_W-1:0] erow;
        req_valid = rq; req_addr = ra; act_done = ac; pre_done = pr;
        close_all = ca; cmd_addr = cm; mem_size = sz;
        eidx = dec_idx(ra, sz);
        erow = dec_row(ra, sz);
        ecls = exp_class(eidx, erow);
        if (ca || sz != m_size) begin
            for (int i = 0; i < 8; i++) m_open[i] = 1'b0;
        end else if (ac) begin
            m_open[dec_idx(cm, sz)] = 1'b1;
            m_page[dec_idx(cm, sz)] = dec_row(cm, sz);
        end else if (pr) begin
            m_open[dec_idx(cm, sz)] = 1'b0;
        end
        m_size = sz;
        @(posedge clk);
        @(negedge clk);
        chk("R2", int'(rsp_valid), int'(rq));
        if (rq) begin
            chk(tag, int'(rsp_class), ecls);
            chk(sz == 0 ? "R3" : sz == 1 ? "R4" : "R5",
                int'({rsp_bank, rsp_leaf}), eidx);
            chk(sz == 0 ? "R3" : sz == 1 ? "R4" : "R5", int'(rsp_row), int'(erow));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [1:0] sz;
        void'($urandom(32'd4711));
        for (int i = 0; i < 8; i++) begin m_open[i] = 1'b0; m_page[i] = '0; end
        m_size = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", int'(rsp_valid), 0);
        rst_n = 1'b1;

        // R1: every leaf closed after reset.
        for (int i = 0; i < 8; i++) cyc(1, mk_addr(0, i, 7, i * 9, 3), 0, 0, 0, '0, 0, "R1");
        // R7: open, then hit; another row gives a miss (R6).
        cyc(0, '0, 1, 0, 0, mk_addr(0, 5, 100, 0, 0), 0, "R7");
        cyc(1, mk_addr(0, 5, 100, 0, 0), 0, 0, 0, '0, 0, "R7");
        cyc(1, mk_addr(0, 5, 101, 0, 0), 0, 0, 0, '0, 0, "R6");
        // R7: reopening a leaf replaces its row; a neighbour stays closed.
        cyc(0, '0, 1, 0, 0, mk_addr(0, 5, 101, 0, 0), 0, "R7");
        cyc(1, mk_addr(0, 5, 100, 0, 0), 0, 0, 0, '0, 0, "R7");
        cyc(1, mk_addr(0, 4, 101, 0, 0), 0, 0, 0, '0, 0, "R7");
        // R12: offset bits and bits above the array do not matter.
        cyc(1, mk_addr(0, 5, 101, 11'h7ff, 3), 0, 0, 0, '0, 0, "R12");
        cyc(1, mk_addr(0, 5, 101, 11'h2a5, 1), 0, 0, 0, '0, 0, "R12");
        // R11: request at the edge of its own activate still sees closed.
        cyc(1, mk_addr(0, 2, 33, 0, 0), 1, 0, 0, mk_addr(0, 2, 33, 0, 0), 0, "R11");
        cyc(1, mk_addr(0, 2, 33, 0, 0), 0, 0, 0, '0, 0, "R11");
        // R8: activate with precharge leaves the leaf open; precharge alone closes.
        cyc(0, '0, 1, 1, 0, mk_addr(0, 6, 9, 0, 0), 0, "R8");
        cyc(1, mk_addr(0, 6, 9, 0, 0), 0, 0, 0, '0, 0, "R8");
        cyc(0, '0, 0, 1, 0, mk_addr(0, 6, 9, 0, 0), 0, "R8");
        cyc(1, mk_addr(0, 6, 9, 0, 0), 0, 0, 0, '0, 0, "R8");
        // R9: close-all outranks a simultaneous activate.
        cyc(0, '0, 1, 0, 1, mk_addr(0, 1, 44, 0, 0), 0, "R9");
        cyc(1, mk_addr(0, 1, 44, 0, 0), 0, 0, 0, '0, 0, "R9");
        cyc(1, mk_addr(0, 2, 33, 0, 0), 0, 0, 0, '0, 0, "R9");
        // R10: open at 64 MB, resize to 128 MB, leaf closed.
        cyc(0, '0, 1, 0, 0, mk_addr(0, 3, 12, 0, 0), 0, "R10");
        cyc(0, '0, 0, 0, 0, '0, 1, "R10");
        cyc(1, mk_addr(1, 3, 12, 0, 0), 0, 0, 0, '0, 1, "R10");
        // R4 and R5 field positions, with junk above the array for R4.
        cyc(0, '0, 1, 0, 0, mk_addr(1, 7, 8191, 5, 1), 1, "R4");
        cyc(1, mk_addr(1, 7, 8191, 77, 1), 0, 0, 0, '0, 1, "R4");
        cyc(0, '0, 0, 0, 0, '0, 2, "R5");
        cyc(0, '0, 1, 0, 0, mk_addr(2, 6, 16383, 0, 0), 2, "R5");
        cyc(1, mk_addr(2, 6, 16383, 3, 0), 0, 0, 0, '0, 3, "R5");

        // Random traffic over a small row pool.
        sz = 2'd0;
        for (int n = 0; n < 4000; n++) begin
            int rows[3] = '{5, 9, 200};
            int rr, cr;
            if ($urandom % 300 == 0) sz = 2'($urandom % 4);
            rr = ($urandom % 8 == 0) ? int'($urandom % 4096) : rows[$urandom % 3];
            cr = rows[$urandom % 3];
            cyc($urandom % 4 != 0,
                mk_addr(sz, int'($urandom % 8), rr, int'($urandom), int'($urandom % 4)),
                $urandom % 5 == 0, $urandom % 9 == 0, $urandom % 70 == 0,
                mk_addr(sz, int'($urandom % 8), cr, int'($urandom), int'($urandom % 4)),
                sz, "R6");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule